// File: doc/BRIEF.md
# Configurable External Request Detector

This block watches a set of asynchronous external pins, eight by default, and turns activity on each pin into a request. Every channel has its own two-bit trigger-type field. Two of the four types are level conditions, low or high. The other two are edge conditions, rising or falling. Each channel also has its own enable bit and its own routing bit. The routing bit sends the request either to the interrupt controller or to a data-transfer service as a transfer trigger. Channels never share detection state.

Each pin first passes through a two-flop synchronizer. A level trigger produces a request for as long as the synchronized level matches and the channel is enabled. An edge trigger sets a sticky flag. Software clears that flag by writing 1 to its bit. A small register port gives access to the configuration and the flag view. Writes take effect on the clock edge. Reads are combinational.

Top module: `ext_req_detector`

## Requirements
- R1: After reset, all registers read 0 and both request outputs are 0. The register map is: address 0 is the enable mask (bit i for channel i); address 1 is the routing mask (bit i = 1 sends channel i to `xfer_req`); address 2 holds the trigger fields, with channel i in bits [2i+1:2i]; address 3 is the flag view.
- R2: Trigger code 00 is low level and code 01 is high level. An enabled level channel requests while its synchronized pin matches the level. The request appears two clocks after the pin changes and drops two clocks after the pin stops matching. It is never sticky.
- R3: Trigger code 10 is rising edge. On an enabled channel, a 0-to-1 pin change sets the flag and the request three clocks later. The flag stays set after the pin returns to 0. A falling change does nothing.
- R4: Trigger code 11 is falling edge. It behaves like R3 with the polarity swapped. A rising change does nothing.
- R5: Writing to address 3 clears the edge flag of every channel whose data bit is 1. Bits written as 0 have no effect. When a clear and a new edge land in the same cycle, the flag stays set.
- R6: An edge seen while a channel is disabled never sets its flag. A disabled channel raises no request. A flag already set is kept, hidden, and presented again once the channel is re-enabled.
- R7: Writing a different trigger code for a channel clears its pending edge flag. Rewriting the same code leaves the flag unchanged.
- R8: A request goes to `irq_req` when its routing bit is 0 and to `xfer_req` when it is 1. It never goes to both.
- R9: Addresses 0 to 2 read back the last written values. In the flag view, bit i is 1 when channel i has a set edge flag, or when it is enabled and its level condition holds.
- R10: Channels are independent: activity on one pin never changes another channel's flag or request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NCH | Asynchronous external request pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 2*NCH | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 2*NCH | Register read data (combinational) |
| irq_req | output | NCH | Requests routed to the interrupt controller |
| xfer_req | output | NCH | Requests routed as data-transfer triggers |

## Verification
The bench builds the block with its defaults: eight channels and a two-stage synchronizer. With these values every channel index can be reached, and the trigger register is a full 16 bits wide. The bench can therefore check the field packing at the top channel as well as at the bottom. The fixed synchronizer depth gives exact latency figures: two clocks for a level request and three for an edge flag. It also lets the bench line up a clear write and a new edge in the same cycle.

// File: rtl/ext_req_pkg.sv
package ext_req_pkg;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_e;

    localparam logic [1:0] ADDR_ENABLE = 2'd0;
    localparam logic [1:0] ADDR_ROUTE  = 2'd1;
    localparam logic [1:0] ADDR_TRIG   = 2'd2;
    localparam logic [1:0] ADDR_FLAG   = 2'd3;

    typedef struct packed {
        logic prev;
        logic flag;
    } chan_state_t;

endpackage

// File: rtl/ext_req_sync.sv
module ext_req_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/ext_req_channel.sv
module ext_req_channel
    import ext_req_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pin_s,
    input  logic  enable,
    input  trig_e trig,
    input  logic  clr,
    input  logic  trig_chg,
    output logic  req,
    output logic  status
);
    chan_state_t state_d, state_q;
    logic rise, fall, edge_hit, level_hit;

    always_comb begin
        rise = pin_s & ~state_q.prev;
        fall = ~pin_s & state_q.prev;
        edge_hit  = 1'b0;
        level_hit = 1'b0;
        case (trig)
            TRIG_LOW:  level_hit = ~pin_s;
            TRIG_HIGH: level_hit = pin_s;
            TRIG_RISE: edge_hit  = rise;
            TRIG_FALL: edge_hit  = fall;
            default:   edge_hit  = 1'b0;
        endcase

        state_d      = state_q;
        state_d.prev = pin_s;
        if (clr)                 state_d.flag = 1'b0;
        if (enable && edge_hit)  state_d.flag = 1'b1;
        if (trig_chg)            state_d.flag = 1'b0;

        req    = enable & (level_hit | state_q.flag);
        status = (enable & level_hit) | state_q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // R6
    no_set_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !state_q.flag) |=> !state_q.flag);

    // R7
    type_change_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_chg |=> !state_q.flag);

    // R2
    level_no_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig == TRIG_LOW || trig == TRIG_HIGH) |-> !state_q.flag);

    // R5
    clear_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !enable) |=> !state_q.flag);
endmodule

// File: rtl/ext_req_regs.sv
module ext_req_regs
    import ext_req_pkg::*;
#(
    parameter int NCH = 8,
    localparam int REG_W = 2 * NCH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    input  logic [NCH-1:0]   status,
    output logic [REG_W-1:0] rd_data,
    output logic [NCH-1:0]   enable,
    output logic [NCH-1:0]   route,
    output logic [REG_W-1:0] trig,
    output logic [NCH-1:0]   clr,
    output logic [NCH-1:0]   trig_chg
);
    typedef struct packed {
        logic [NCH-1:0]   en;
        logic [NCH-1:0]   rt;
        logic [REG_W-1:0] tr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d    = cfg_q;
        clr      = '0;
        trig_chg = '0;
        if (wr_en) begin
            case (wr_addr)
                ADDR_ENABLE: cfg_d.en = wr_data[NCH-1:0];
                ADDR_ROUTE:  cfg_d.rt = wr_data[NCH-1:0];
                ADDR_TRIG: begin
                    cfg_d.tr = wr_data;
                    for (int i = 0; i < NCH; i++) begin
                        trig_chg[i] = (wr_data[2*i +: 2] != cfg_q.tr[2*i +: 2]);
                    end
                end
                default:     clr = wr_data[NCH-1:0];
            endcase
        end

        rd_data = '0;
        case (rd_addr)
            ADDR_ENABLE: rd_data[NCH-1:0] = cfg_q.en;
            ADDR_ROUTE:  rd_data[NCH-1:0] = cfg_q.rt;
            ADDR_TRIG:   rd_data          = cfg_q.tr;
            default:     rd_data[NCH-1:0] = status;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign enable = cfg_q.en;
    assign route  = cfg_q.rt;
    assign trig   = cfg_q.tr;

    // R7
    same_code_no_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_TRIG && wr_data == cfg_q.tr) |-> (trig_chg == '0));
endmodule

// File: rtl/ext_req_detector.sv
module ext_req_detector
    import ext_req_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int SYNC_STAGES = 2,
    localparam int REG_W      = 2 * NCH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   pin_in,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [REG_W-1:0] rd_data,
    output logic [NCH-1:0]   irq_req,
    output logic [NCH-1:0]   xfer_req
);
    logic [NCH-1:0]   pin_s, enable, route, clr, trig_chg, req, status;
    logic [REG_W-1:0] trig;

    ext_req_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (pin_s)
    );

    ext_req_regs #(.NCH(NCH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .status  (status),
        .rd_data (rd_data),
        .enable  (enable),
        .route   (route),
        .trig    (trig),
        .clr     (clr),
        .trig_chg(trig_chg)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        ext_req_channel u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_s   (pin_s[g]),
            .enable  (enable[g]),
            .trig    (trig_e'(trig[2*g +: 2])),
            .clr     (clr[g]),
            .trig_chg(trig_chg[g]),
            .req     (req[g]),
            .status  (status[g])
        );
    end

    assign irq_req  = req & ~route;
    assign xfer_req = req & route;

    // R6
    disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_req | xfer_req) & ~enable) == '0);

    // R8
    route_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req & xfer_req) == '0);
endmodule

// File: tb/ext_req_detector_bench.sv
module ext_req_detector_bench;
    localparam int NCH = 8;
    localparam int REG_W = 2 * NCH;

    // {channel[2:0], trigger[1:0], pin_start, pin_end, expected_irq}
    localparam logic [7:0] VECS [8] = '{
        8'b000_00_1_0_1, 8'b001_01_0_1_1, 8'b010_10_0_1_1, 8'b011_11_1_0_1,
        8'b100_10_1_0_0, 8'b101_11_0_1_0, 8'b110_00_0_1_0, 8'b111_01_1_0_0
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] pin = '0;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [REG_W-1:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [REG_W-1:0] rd_data;
    logic [NCH-1:0] irq_req, xfer_req;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ext_req_detector u_ext_req_detector (
        .clk(clk), .rst_n(rst_n), .pin_in(pin), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_req(irq_req), .xfer_req(xfer_req)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [REG_W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [REG_W-1:0] v);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    task automatic cleanup();
        wr(2'd0, '0); wr(2'd1, '0); wr(2'd2, '0);
        pin = '0;
        tick(4);
        wr(2'd3, '1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [REG_W-1:0] v;
        tick(2);
        // R1 reset state
        check("R1 irq after reset", 32'(irq_req), 0);
        check("R1 xfer after reset", 32'(xfer_req), 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 register reset value", 32'(v), 0);
        end
        rst_n = 1'b1;
        tick(2);

        // Vector table: R2 R3 R4 across every channel
        for (int k = 0; k < 8; k++) begin
            logic [7:0] e;
            int ch;
            e = VECS[k];
            ch = int'(e[7:5]);
            cleanup();
            wr(2'd2, REG_W'(e[4:3]) << (2 * ch));
            wr(2'd0, NCH'(1) << ch);
            pin[ch] = e[2];
            tick(4);
            wr(2'd3, '1);
            pin[ch] = e[1];
            tick(4);
            check("R2/R3/R4 table request", 32'(irq_req[ch]), 32'(e[0]));
            check("R10 table other channels", 32'(irq_req & ~(NCH'(1) << ch)), 0);
        end

        // R3 latency and stickiness on channel 2
        cleanup();
        wr(2'd2, REG_W'(2'b10) << 4);
        wr(2'd0, 8'h04);
        pin[2] = 1'b1;
        tick(2);
        check("R3 no flag after two clocks", 32'(irq_req[2]), 0);
        tick(1);
        check("R3 flag after three clocks", 32'(irq_req[2]), 1);
        pin[2] = 1'b0;
        tick(4);
        check("R3 flag sticky after pin low", 32'(irq_req[2]), 1);
        rd(2'd3, v);
        check("R9 flag view edge", 32'(v), 32'h04);

        // R5 clear semantics
        wr(2'd3, '0);
        check("R5 write 0 keeps flag", 32'(irq_req[2]), 1);
        wr(2'd3, 16'h0004);
        check("R5 write 1 clears flag", 32'(irq_req[2]), 0);
        pin[2] = 1'b1;
        tick(2);
        wr(2'd3, 16'h0004);
        check("R5 set wins over clear", 32'(irq_req[2]), 1);

        // R7 trigger change
        wr(2'd2, REG_W'(2'b10) << 4);
        check("R7 same code keeps flag", 32'(irq_req[2]), 1);
        wr(2'd2, REG_W'(2'b11) << 4);
        check("R7 new code clears flag", 32'(irq_req[2]), 0);
        rd(2'd3, v);
        check("R7 flag view after change", 32'(v), 0);

        // R4 falling edge on channel 3
        cleanup();
        wr(2'd2, REG_W'(2'b11) << 6);
        wr(2'd0, 8'h08);
        pin[3] = 1'b1;
        tick(4);
        check("R4 rising ignored", 32'(irq_req[3]), 0);
        pin[3] = 1'b0;
        tick(2);
        check("R4 no flag after two clocks", 32'(irq_req[3]), 0);
        tick(1);
        check("R4 flag after three clocks", 32'(irq_req[3]), 1);

        // R2 level latency on channel 1
        cleanup();
        wr(2'd2, REG_W'(2'b01) << 2);
        wr(2'd0, 8'h02);
        pin[1] = 1'b1;
        tick(1);
        check("R2 level not yet", 32'(irq_req[1]), 0);
        tick(1);
        check("R2 level after two clocks", 32'(irq_req[1]), 1);
        rd(2'd3, v);
        check("R9 flag view level", 32'(v), 32'h02);
        pin[1] = 1'b0;
        tick(2);
        check("R2 level drops", 32'(irq_req[1]), 0);
        pin[1] = 1'b1;
        wr(2'd0, 8'h00);
        tick(2);
        check("R6 disabled level silent", 32'(irq_req), 0);

        // R6 disabled edge
        cleanup();
        wr(2'd2, REG_W'(2'b10) << 4);
        pin[2] = 1'b1;
        tick(4);
        rd(2'd3, v);
        check("R6 disabled no flag", 32'(v), 0);
        wr(2'd0, 8'h04);
        check("R6 enable shows nothing", 32'(irq_req[2]), 0);
        pin[2] = 1'b0;
        tick(3);
        pin[2] = 1'b1;
        tick(4);
        check("R6 enabled edge sets", 32'(irq_req[2]), 1);
        wr(2'd0, 8'h00);
        check("R6 masked when disabled", 32'(irq_req), 0);
        wr(2'd0, 8'h04);
        check("R6 retained flag returns", 32'(irq_req[2]), 1);

        // R8 routing
        wr(2'd1, 8'h04);
        check("R8 routed to transfer", 32'(xfer_req), 32'h04);
        check("R8 not on interrupt", 32'(irq_req), 0);
        wr(2'd1, 8'h00);
        check("R8 routed to interrupt", 32'(irq_req), 32'h04);
        check("R8 transfer cleared", 32'(xfer_req), 0);

        // R10 independence
        cleanup();
        wr(2'd2, 16'h000A);
        wr(2'd0, 8'h03);
        pin[0] = 1'b1;
        tick(4);
        rd(2'd3, v);
        check("R10 only channel 0 flagged", 32'(v), 32'h01);

        // R9 readback
        wr(2'd0, 8'hA5);
        rd(2'd0, v);
        check("R9 enable readback", 32'(v), 32'hA5);
        wr(2'd1, 8'h3C);
        rd(2'd1, v);
        check("R9 route readback", 32'(v), 32'h3C);
        wr(2'd2, 16'hC9E4);
        rd(2'd2, v);
        check("R9 trigger readback", 32'(v), 32'hC9E4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule